// File: doc/BRIEF.md
# Carrier Clock Divider with Movable Phase

This block divides an external RF carrier clock (for instance 13.56 MHz) by a programmable amount. An up-counter runs on every carrier edge and restarts from zero after it reaches a period value. Two compare points then shape the outputs. The main output goes high at a rise point and low at the period point. An auxiliary output goes high on a rising edge of an external event input and low at a fall compare point. When the main output is looped back into the event input, the auxiliary output becomes a waveform close to 50% duty.

Software drives the block through a one-cycle write strobe with a one-bit address and a 16-bit data word.
- **Divider write:** loads a new period and places both compare points for about 50% duty.
- **Phase write:** adds a signed step to both compare points, modulo the period. The running count is not touched, so the phase of the output moves smoothly.

If a new divider is smaller than the current count, the block raises a busy flag. It lets the counter keep running until the count is a multiple of the new divider, then restarts the counter there, so the phase relation is kept. A gate input freezes the counter, and a trigger input restarts it at once.

Top module: `cpd_top`

## Requirements
- R1: After reset the outputs and busy flag are low and the divider is 128: period value 128, rise point 1, fall point 65, so the period is 129 carrier cycles.
- R2: While the gate is high the count advances by one per carrier edge and returns to 0 on the edge where it equals the period value. The main output goes high on the edge where the count equals the rise point, and low on the edge where it equals the period value.
- R3: A write to address 0 with value d sets the period value to d, the rise point to 1 and the fall point to 1 + floor(d/2). Values below 2 are treated as 2.
- R4: The auxiliary output goes high on the edge after the event input is first seen high (a rising edge) and low on the edge where the count equals the fall point. When both happen on one edge, the fall wins.
- R5: A trigger pulse sets the count to 0 and drives both outputs low on the same edge.
- R6: A write to address 1 with signed step s, where |s| is at most the period value, replaces each compare point x with (x + s) wrapped into 0..period-1. If the new rise point is 0, both points are then raised by 1. The count continues undisturbed.
- R7: A divider write with the gate high, taking effect while the count is above the new divider (and the next count is not 0), raises the busy output. The counter keeps running. On a later edge where the count is a multiple of the new divider, a restart acts as in R5 and busy falls.
- R8: With the gate low the count and main output hold their values, and a divider write starts no wait: busy stays low.
- R9: Writes to either address while busy is high are ignored.
- R10: On an edge where the count equals the period value, the main output goes low even if a rise match happens on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Carrier clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gate_i | input | 1 | Counter runs while high |
| event_i | input | 1 | External event; a rising edge sets the auxiliary output |
| swtrg_i | input | 1 | Restart trigger |
| wr_valid_i | input | 1 | Write strobe |
| wr_addr_i | input | 1 | 0 = divider, 1 = phase step |
| wr_data_i | input | 16 | Divider value or signed phase step |
| div_out_o | output | 1 | Divided main output |
| aux_out_o | output | 1 | Auxiliary output |
| busy_o | output | 1 | High while a divider change waits for a boundary |

## Verification
The bench sweeps every divider from 0 to 12 with the event input looped back. For each one it predicts both outputs from the count position arithmetically. A design with an off-by-one period, wrong fall point placement or missing clamping would show a shifted edge. Divisors 2 and 3 put the event rise and the fall match on the same edge, so getting the clear priority wrong would leave the auxiliary output stuck high.

Phase steps of both signs, including one that wraps the rise point to zero, are applied mid-stream. The bench then checks the outputs against the unbroken count, which catches a wrong modulo, a missing bump, or a counter disturbed by the write.

The boundary wait is checked by asserting that the restart lands on a multiple of the new divider. A phase write during the wait must leave no trace. The gated hold is checked by resuming without a restart and continuing the same prediction.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
    typedef enum logic {
        ADR_DIV   = 1'b0,
        ADR_PHASE = 1'b1
    } cpd_addr_e;
endpackage

// File: rtl/cpd_rise.sv
module cpd_rise (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sig_i,
    output logic rise_o
);
    logic prev_d, prev_q;

    always_comb prev_d = sig_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= prev_d;
    end

    assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/cpd_modwrap.sv
module cpd_modwrap #(
    parameter int W = 16
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] inc_i,
    input  logic [W-1:0] mod_i,
    output logic [W-1:0] res_o
);
    localparam int SW = W + 2;

    logic signed [SW-1:0] sum, modv;

    always_comb begin
        modv = signed'({2'b00, mod_i});
        sum  = signed'({2'b00, base_i}) + signed'({{2{inc_i[W-1]}}, inc_i});
        if (sum < 0)          res_o = W'(sum + modv);
        else if (sum >= modv) res_o = W'(sum - modv);
        else                  res_o = W'(sum);
    end
endmodule

// File: rtl/cpd_top.sv
module cpd_top #(
    parameter int W       = 16,
    parameter int RST_DIV = 128
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         gate_i,
    input  logic         event_i,
    input  logic         swtrg_i,
    input  logic         wr_valid_i,
    input  logic         wr_addr_i,
    input  logic [W-1:0] wr_data_i,
    output logic         div_out_o,
    output logic         aux_out_o,
    output logic         busy_o
);
    import cpd_pkg::*;

    localparam logic [W-1:0] ONE     = W'(1);
    localparam logic [W-1:0] MIN_DIV = W'(2);
    localparam logic [W-1:0] RST_RC  = W'(RST_DIV);
    localparam logic [W-1:0] RST_RB  = W'(1 + RST_DIV / 2);
    localparam int           NCMP    = 2;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rc;
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        logic [W-1:0] res;
        logic         main;
        logic         aux;
        logic         busy;
    } state_t;

    state_t       st_d, st_q;
    logic         ev_rise;
    logic [W-1:0] cmp_cur [NCMP];
    logic [W-1:0] cmp_nxt [NCMP];
    logic [W-1:0] new_div;
    logic         run, hit_ra, hit_rb, hit_rc, at_bound;
    logic [W-1:0] cnt_w, rc_w, ra_w;

    cpd_rise u_rise (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sig_i  (event_i),
        .rise_o (ev_rise)
    );

    assign cmp_cur[0] = st_q.ra;
    assign cmp_cur[1] = st_q.rb;

    generate
        for (genvar g = 0; g < NCMP; g++) begin : g_shift
            cpd_modwrap #(.W(W)) u_wrap (
                .base_i (cmp_cur[g]),
                .inc_i  (wr_data_i),
                .mod_i  (st_q.rc),
                .res_o  (cmp_nxt[g])
            );
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        run      = gate_i;
        hit_ra   = (st_q.cnt == st_q.ra);
        hit_rb   = (st_q.cnt == st_q.rb);
        hit_rc   = (st_q.cnt == st_q.rc);
        at_bound = st_q.busy && run && (st_q.res == '0 || st_q.cnt == '0);
        new_div  = (wr_data_i < MIN_DIV) ? MIN_DIV : wr_data_i;

        if (run) begin
            st_d.cnt = hit_rc ? '0 : st_q.cnt + ONE;
            // period match outranks rise match
            if (hit_rc)      st_d.main = 1'b0;
            else if (hit_ra) st_d.main = 1'b1;
            // residue of the count modulo the new divider, reduced step by step
            if (st_q.busy) begin
                if (st_q.res >= st_q.rc)         st_d.res = st_q.res + ONE - st_q.rc;
                else if (st_q.res + ONE == st_q.rc) st_d.res = '0;
                else                             st_d.res = st_q.res + ONE;
            end
        end

        if (run && hit_rb) st_d.aux = 1'b0;
        else if (ev_rise)  st_d.aux = 1'b1;

        if (wr_valid_i && !st_q.busy) begin
            if (cpd_addr_e'(wr_addr_i) == ADR_DIV) begin
                st_d.rc = new_div;
                st_d.ra = ONE;
                st_d.rb = ONE + (new_div >> 1);
                if (run && st_q.cnt > new_div && st_d.cnt != '0) begin
                    st_d.busy = 1'b1;
                    st_d.res  = st_d.cnt;
                end
            end else begin
                st_d.ra = cmp_nxt[0];
                st_d.rb = cmp_nxt[1];
                if (cmp_nxt[0] == '0) begin
                    st_d.ra = ONE;
                    st_d.rb = cmp_nxt[1] + ONE;
                end
            end
        end

        if (swtrg_i || at_bound) begin
            st_d.cnt  = '0;
            st_d.main = 1'b0;
            st_d.aux  = 1'b0;
            st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{cnt: '0, rc: RST_RC, ra: ONE, rb: RST_RB, res: '0,
                      main: 1'b0, aux: 1'b0, busy: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign div_out_o = st_q.main;
    assign aux_out_o = st_q.aux;
    assign busy_o    = st_q.busy;
    assign cnt_w     = st_q.cnt;
    assign rc_w      = st_q.rc;
    assign ra_w      = st_q.ra;
endmodule

// File: rtl/cpd_chk.sv
module cpd_chk #(
    parameter int W = 16
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         gate_i,
    input logic         swtrg_i,
    input logic         wr_valid_i,
    input logic         div_out_o,
    input logic         aux_out_o,
    input logic         busy_o,
    input logic [W-1:0] cnt,
    input logic [W-1:0] rc,
    input logic [W-1:0] ra
);
    AST_TRG_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        swtrg_i |=> (!div_out_o && !aux_out_o)); // R5

    AST_PERIOD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate_i && cnt == rc) |=> !div_out_o); // R10

    AST_GATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!gate_i && !swtrg_i) |=> ($stable(cnt) && $stable(div_out_o))); // R8

    AST_RISE_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ra != '0); // R6

    AST_BUSY_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> (cnt > rc)); // R7

    AST_BUSY_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (cnt == '0 && !div_out_o)); // R7

    AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && wr_valid_i) |=> ($stable(rc) && $stable(ra))); // R9
endmodule

bind cpd_top cpd_chk #(.W(W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gate_i     (gate_i),
    .swtrg_i    (swtrg_i),
    .wr_valid_i (wr_valid_i),
    .div_out_o  (div_out_o),
    .aux_out_o  (aux_out_o),
    .busy_o     (busy_o),
    .cnt        (cnt_w),
    .rc         (rc_w),
    .ra         (ra_w)
);

// File: tb/tb_cpd_top.sv
module tb_cpd_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        gate_i = 1'b1;
    logic        swtrg_i = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic        wr_addr_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        loop_en = 1'b1;
    logic        ev_drv = 1'b0;
    logic        event_w;
    logic        div_out_o, aux_out_o, busy_o;

    int checks = 0;
    int errors = 0;
    int j = 0;

    always #4 clk_i = ~clk_i;

    assign event_w = loop_en ? div_out_o : ev_drv;

    cpd_top dut (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .gate_i     (gate_i),
        .event_i    (event_w),
        .swtrg_i    (swtrg_i),
        .wr_valid_i (wr_valid_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .div_out_o  (div_out_o),
        .aux_out_o  (aux_out_o),
        .busy_o     (busy_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk_i);
        #1;
        j++;
    endtask

    task automatic hold_step();
        @(posedge clk_i);
        #1;
    endtask

    task automatic trig();
        swtrg_i = 1'b1;
        step();
        swtrg_i = 1'b0;
        j = 0;
    endtask

    task automatic write(input logic adr, input int val);
        wr_valid_i = 1'b1;
        wr_addr_i  = adr;
        wr_data_i  = 16'(val);
        step();
        wr_valid_i = 1'b0;
    endtask

    task automatic set_div(input int d);
        trig();
        write(1'b0, d);
        check(busy_o == 1'b0, "R7 no wait at count 0", int'(busy_o), 0);
        trig();
    endtask

    function automatic int wrapmod(input int a, input int m);
        int r;
        r = a % m;
        if (r < 0) r += m;
        return r;
    endfunction

    // predicted outputs from count position p = (j-1) mod (rc+1)
    task automatic wave(input int n, input int ra, input int rb, input int rc, input string tag);
        for (int i = 0; i < n; i++) begin
            int p, s, em, ea;
            step();
            p  = (j - 1) % (rc + 1);
            em = (p >= ra && p < rc) ? 1 : 0;
            check(int'(div_out_o) == em, tag, int'(div_out_o), em);
            if (j > rc + 2) begin
                s = ra + 1;
                if (s == rb)     ea = 0;
                else if (s < rb) ea = (p >= s && p < rb) ? 1 : 0;
                else             ea = (p >= s || p < rb) ? 1 : 0;
                check(int'(aux_out_o) == ea, {tag, " aux R4"}, int'(aux_out_o), ea);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int ra, rb, rc, k, m, tc;
        int incs [4] = '{4, -7, 2, -9};

        // R1: reset state
        repeat (3) hold_step();
        check(div_out_o == 1'b0, "R1 main", int'(div_out_o), 0);
        check(aux_out_o == 1'b0, "R1 aux", int'(aux_out_o), 0);
        check(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
        rst_ni = 1'b1;
        j = 0;
        wave(300, 1, 65, 128, "R1");

        // R2 R3 R4 R10: divider sweep incl. clamping and coincident aux events
        for (int d = 0; d <= 12; d++) begin
            int dd;
            dd = (d < 2) ? 2 : d;
            set_div(d);
            wave(3 * (dd + 1) + 6, 1, 1 + dd / 2, dd, "R2 R3 R10");
        end

        // R6: phase steps applied mid-stream, count undisturbed
        set_div(10);
        ra = 1; rb = 6; rc = 10;
        wave(25, ra, rb, rc, "R6 base");
        for (int i = 0; i < 4; i++) begin
            int nra, nrb;
            write(1'b1, incs[i]);
            nra = wrapmod(ra + incs[i], rc);
            nrb = wrapmod(rb + incs[i], rc);
            if (nra == 0) begin
                nra = 1;
                nrb = nrb + 1;
            end
            ra = nra; rb = nrb;
            repeat (2 * (rc + 1)) step();
            wave(33, ra, rb, rc, "R6");
        end

        // R5: trigger while both outputs high
        k = 0;
        while (!(div_out_o && aux_out_o) && k < 40) begin
            step();
            k++;
        end
        check(div_out_o && aux_out_o, "R5 setup", int'(div_out_o && aux_out_o), 1);
        trig();
        check(div_out_o == 1'b0, "R5 main", int'(div_out_o), 0);
        check(aux_out_o == 1'b0, "R5 aux", int'(aux_out_o), 0);
        wave(30, ra, rb, rc, "R5 after");

        // R7 R9: shrink divider below the running count
        set_div(20);
        repeat (15) step();
        write(1'b0, 6);
        check(busy_o == 1'b1, "R7 busy rise", int'(busy_o), 1);
        write(1'b1, 3);
        k = 1;
        while (busy_o && k < 400) begin
            step();
            k++;
        end
        check(busy_o == 1'b0, "R7 busy fall", int'(busy_o), 0);
        tc = 15 + k;
        check(tc % 6 == 0 && tc > 15, "R7 restart on multiple", tc % 6, 0);
        check(div_out_o == 1'b0, "R7 restart main", int'(div_out_o), 0);
        j = 0;
        wave(30, 1, 4, 6, "R9 phase ignored");

        // R8: gate hold and continuation
        set_div(10);
        wave(5, 1, 6, 10, "R8 pre");
        gate_i = 1'b0;
        m = int'(div_out_o);
        for (int i = 0; i < 20; i++) begin
            hold_step();
            check(int'(div_out_o) == m, "R8 hold", int'(div_out_o), m);
        end
        gate_i = 1'b1;
        wave(40, 1, 6, 10, "R8 resume");
        gate_i = 1'b0;
        hold_step();
        write(1'b0, 3);
        check(busy_o == 1'b0, "R8 no wait", int'(busy_o), 0);
        hold_step();
        check(busy_o == 1'b0, "R8 no wait later", int'(busy_o), 0);
        gate_i = 1'b1;
        trig();
        wave(20, 1, 2, 3, "R8 after");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule